// File: doc/BRIEF.md
# Serial Character Transmitter with Ninth Bit

This block turns bytes written by a host into asynchronous serial frames on a single output line. The host writes a character into a holding register through a small read/write register port. Whenever the shift engine is idle and enabled, it takes the held character and sends a low start bit, then the data bits with the least significant bit first, then an optional ninth bit, then a high stop bit. A mode bit picks 8-bit or 9-bit characters. In 9-bit mode the ninth bit comes from its own control bit, which is sampled at the moment the character moves into the shift engine.

Two status flags tell the host how far the transmitter has got. One shows that the holding register can take a new character. The other shows that the line has gone quiet with nothing left to send. Each flag has its own enable into a single level interrupt output. A break command makes the engine send frames that are low throughout, stop position included, for as long as the command stays set. Bit timing comes from an external baud tick: each bit lasts `OVS` ticks.

The register port has no back-pressure. A write is always taken in the cycle `reg_we` is high, and a read returns the addressed value combinationally. A data write made while an earlier character is still waiting replaces that character.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, the interrupt output is low, status (address 2) reads empty=1 in bit 0 and done=1 in bit 1, and control bits 0..3 read 0.
- R2: With control bit 4 clear, each frame is one low start bit, DW data bits LSB first, and one high stop bit. Each bit lasts OVS baud ticks.
- R3: With control bit 4 set, a ninth bit equal to control bit 5 is sent between the last data bit and the stop bit.
- R4: The ninth bit of a frame is the value control bit 5 holds when that character moves into the shifter. Later changes do not alter that frame.
- R5: The empty flag (status bit 0) clears on a write to the data register (address 0) and sets when the character moves into the shifter. A character that is waiting when a frame ends is sent in the next frame.
- R6: The done flag (status bit 1) is 1 exactly when the shifter is idle and the empty flag is 1.
- R7: The interrupt output equals (empty AND control bit 2) OR (done AND control bit 3).
- R8: While control bit 0 (enable) is 0, the line stays high, no frame starts, and a written character stays waiting until enable is set.
- R9: While control bit 1 (break) is set with enable set and no character waiting, frames that are low in every bit position, stop included, are sent back to back.
- R10: Reset clears control bits 0..3 and leaves control bits 4 and 5 at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse per oversample period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| tx_line | output | 1 | Serial output, idles high |
| tx_irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with DW=8 and OVS=4 and pulses the baud tick every third clock. A bit then lasts twelve cycles, so a frame is about 120 cycles. That brings back-to-back characters, both character lengths, a change of the ninth bit while a character waits, and two consecutive break frames within a short run. Because ticks arrive only every third cycle, the bench also sees that the shifter counts ticks and not clocks, and that the start bit is shortened by however far the load lands from the next tick.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // control layout, lowest bit first: en, brk, eie, cie, wide, nine
  typedef struct packed {
    logic nine;
    logic wide;
    logic cie;
    logic eie;
    logic brk;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          load_i,
  input  logic          done_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic [DW-1:0] rdata_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic          wr_data, wr_ctrl;
  logic [DW-1:0] data_q;
  logic          empty_q;
  logic          en_q, brk_q, eie_q, cie_q;
  logic          wide_q, nine_q;

  assign wr_data = we_i && (addr_i == ADDR_DATA);
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      brk_q   <= 1'b0;
      eie_q   <= 1'b0;
      cie_q   <= 1'b0;
      data_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[0];
        brk_q <= wdata_i[1];
        eie_q <= wdata_i[2];
        cie_q <= wdata_i[3];
      end
      if (wr_data) begin
        data_q  <= wdata_i;
        empty_q <= 1'b0;
      end else if (load_i) begin
        empty_q <= 1'b1;
      end
    end
  end

  // length and ninth-bit value survive reset
  always_ff @(posedge clk) begin
    if (wr_ctrl) begin
      wide_q <= wdata_i[4];
      nine_q <= wdata_i[5];
    end
  end

  assign ctrl_o  = '{nine: nine_q, wide: wide_q, cie: cie_q,
                     eie: eie_q, brk: brk_q, en: en_q};
  assign data_o  = data_q;
  assign empty_o = empty_q;

  always_comb begin
    case (addr_i)
      ADDR_DATA: rdata_o = data_q;
      ADDR_CTRL: rdata_o = DW'(CTRL_W'(ctrl_o));
      ADDR_STAT: rdata_o = DW'({done_i, empty_q});
      default:   rdata_o = '0;
    endcase
  end

  // R5
  empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !empty_q);
  // R5
  empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !wr_data) |=> empty_q);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          brk_i,
  input  logic          wide_i,
  input  logic          nine_i,
  input  logic          pend_i,
  input  logic [DW-1:0] data_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          tx_o
);
  localparam int FW  = DW + 3;
  localparam int BIW = $clog2(FW);
  localparam int CW  = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0]  CNT_LAST  = CW'(OVS - 1);
  localparam logic [BIW-1:0] LAST_WIDE = BIW'(FW - 1);
  localparam logic [BIW-1:0] LAST_NARR = BIW'(FW - 2);

  logic           busy_q;
  logic [FW-1:0]  sh_q;
  logic [BIW-1:0] idx_q, last_q;
  logic [CW-1:0]  cnt_q;
  logic           start_data, start_brk;
  logic [FW-1:0]  frame;

  assign start_data = !busy_q && en_i && pend_i;
  assign start_brk  = !busy_q && en_i && !pend_i && brk_i;

  // stop, ninth (or spare stop), data, start
  always_comb begin
    frame = {1'b1, (wide_i ? nine_i : 1'b1), data_i, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      last_q <= '0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (start_data || start_brk) begin
      busy_q <= 1'b1;
      sh_q   <= start_data ? frame : '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      last_q <= wide_i ? LAST_WIDE : LAST_NARR;
    end else if (busy_q && tick_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {1'b1, sh_q[FW-1:1]};
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign load_o = start_data;
  assign busy_o = busy_q;
  assign tx_o   = !busy_q || sh_q[0];

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !tx_o);
  // R8
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> tx_o);
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= last_q));
endmodule

// File: rtl/sertx_irq.sv
module sertx_irq (
  input  logic eie_i,
  input  logic cie_i,
  input  logic empty_i,
  input  logic done_i,
  output logic irq_o
);
  assign irq_o = (empty_i && eie_i) || (done_i && cie_i);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tx_line,
  output logic          tx_irq
);
  ctrl_t         ctrl;
  logic [DW-1:0] data;
  logic          empty, done, load, busy;

  assign done = !busy && empty;

  sertx_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .load_i  (load),
    .done_i  (done),
    .ctrl_o  (ctrl),
    .data_o  (data),
    .empty_o (empty),
    .rdata_o (reg_rdata)
  );

  sertx_shifter #(.DW(DW), .OVS(OVS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (baud_tick),
    .en_i   (ctrl.en),
    .brk_i  (ctrl.brk),
    .wide_i (ctrl.wide),
    .nine_i (ctrl.nine),
    .pend_i (!empty),
    .data_i (data),
    .load_o (load),
    .busy_o (busy),
    .tx_o   (tx_line)
  );

  sertx_irq u_irq (
    .eie_i   (ctrl.eie),
    .cie_i   (ctrl.cie),
    .empty_i (empty),
    .done_i  (done),
    .irq_o   (tx_irq)
  );

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.cie && !empty) |-> !tx_irq);
  // R8
  no_load_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> !load);
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  localparam int DW  = 8;
  localparam int OVS = 4;
  localparam int TP  = 3;
  localparam int BITC = OVS * TP;

  typedef struct {
    logic [10:0] bits;
    string       req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          baud_tick = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          tx_line, tx_irq;

  int    checks = 0;
  int    errors = 0;
  int    tdiv = 0;
  bit    cur_wide = 1'b0;
  bit    ended = 1'b0;
  item_t expq[$];

  sertx_top #(.DW(DW), .OVS(OVS)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_line(tx_line), .tx_irq(tx_irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv == TP - 1) ? 0 : tdiv + 1;
    baud_tick = (tdiv == 0);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push(input logic [DW-1:0] d, input bit wide, input bit nine, input string req);
    item_t it;
    it.bits = wide ? {1'b1, nine, d, 1'b0} : {1'b0, 1'b1, d, 1'b0};
    it.req  = req;
    expq.push_back(it);
  endtask

  task automatic push_brk(input string req);
    item_t it;
    it.bits = '0;
    it.req  = req;
    expq.push_back(it);
  endtask

  task automatic wait_stat(input int bitno);
    logic [DW-1:0] s;
    int n = 0;
    do begin
      rd(2'd2, s);
      n++;
    end while (s[bitno] !== 1'b1 && n < 5000);
  endtask

  task automatic send(input logic [DW-1:0] d, input bit nine, input string req);
    wait_stat(0);
    push(d, cur_wide, nine, req);
    wr(2'd0, d);
  endtask

  // monitor: decode frames off the line and compare with the queue
  initial begin
    @(posedge rst_n);
    forever begin
      logic [10:0] fr;
      int nb;
      item_t it;
      @(negedge clk);
      while (tx_line !== 1'b0) @(negedge clk);
      nb = cur_wide ? 11 : 10;
      fr = '0;
      repeat (BITC / 2) @(negedge clk);
      for (int k = 0; k < nb; k++) begin
        fr[k] = tx_line;
        if (k < nb - 1) repeat (BITC) @(negedge clk);
      end
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=%h expected=no frame", fr);
      end else begin
        it = expq.pop_front();
        chk(it.req, 32'(fr), 32'(it.bits));
      end
      while (tx_line !== 1'b1) @(negedge clk);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 line", 32'(tx_line), 32'd1);
    chk("R1 irq", 32'(tx_irq), 32'd0);
    rd(2'd2, v); chk("R1 status", 32'(v), 32'h03);
    rd(2'd1, v); chk("R1 ctrl", 32'(v & 8'h0F), 32'h00);

    // R2 8-bit frames, back to back (R5)
    cur_wide = 1'b0;
    wr(2'd1, 8'h01);
    send(8'hA5, 1'b0, "R2 frame A5");
    send(8'h3C, 1'b0, "R5 back-to-back 3C");
    rd(2'd2, v); chk("R5 empty clear while waiting", 32'(v), 32'h00);
    wait_stat(0);
    rd(2'd2, v); chk("R6 done low while shifting", 32'(v), 32'h01);
    send(8'hFF, 1'b0, "R2 frame FF");
    send(8'h00, 1'b0, "R2 frame 00");
    wait_stat(1);
    rd(2'd2, v); chk("R6 done when idle", 32'(v), 32'h03);

    // R3 9-bit frames
    cur_wide = 1'b1;
    wr(2'd1, 8'h31);
    send(8'h5A, 1'b1, "R3 ninth 1");
    wait_stat(1);
    wr(2'd1, 8'h11);
    send(8'h96, 1'b0, "R3 ninth 0");
    wait_stat(1);

    // R4 ninth bit captured at load
    wr(2'd1, 8'h31);
    send(8'h81, 1'b1, "R4 first keeps 1");
    wait_stat(0);
    push(8'h42, 1'b1, 1'b0, "R4 second takes 0");
    wr(2'd0, 8'h42);
    wr(2'd1, 8'h11);
    wait_stat(0);
    wr(2'd1, 8'h31);
    wait_stat(1);

    // R7 / R8 interrupts and disable
    cur_wide = 1'b0;
    wr(2'd1, 8'h04);
    @(negedge clk); chk("R7 irq on empty", 32'(tx_irq), 32'd1);
    push(8'h11, 1'b0, 1'b0, "R8 held byte sent after enable");
    wr(2'd0, 8'h11);
    chk("R7 irq low when waiting", 32'(tx_irq), 32'd0);
    begin
      bit stayed_high = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (tx_line !== 1'b1) stayed_high = 1'b0;
      end
      chk("R8 line high while off", 32'(stayed_high), 32'd1);
    end
    rd(2'd2, v); chk("R8 byte still waiting", 32'(v), 32'h00);
    wr(2'd1, 8'h05);
    @(negedge clk); chk("R7 irq after load", 32'(tx_irq), 32'd1);
    wr(2'd1, 8'h09);
    @(negedge clk); chk("R7 done irq low while busy", 32'(tx_irq), 32'd0);
    wait_stat(1);
    @(negedge clk); chk("R7 done irq when done", 32'(tx_irq), 32'd1);

    // R9 break frames repeat while set
    push_brk("R9 break 1");
    push_brk("R9 break 2");
    wr(2'd1, 8'h03);
    repeat (150) @(negedge clk);
    wr(2'd1, 8'h01);
    wait_stat(1);
    repeat (20) @(negedge clk);
    chk("R9 two breaks seen", 32'(expq.size()), 32'd0);

    // R10 reset keeps length and ninth bit
    wr(2'd1, 8'h3D);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd1, v); chk("R10 ctrl after reset", 32'(v), 32'h30);
    chk("R10 irq after reset", 32'(tx_irq), 32'd0);

    repeat (10) @(negedge clk);
    chk("R2 no missing frames", 32'(expq.size()), 32'd0);
    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule